// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block decides, every cycle, whether a five-stage in-order integer pipeline may advance. It watches the source registers of the instruction sitting in decode and compares them against the destinations of the instructions one and two stages ahead. Branches in this pipeline are compared and resolved in decode, so a branch needs its operands one stage earlier than an ALU instruction does. As a result, the controller must stall for producers that forwarding cannot yet cover.

When the pipeline cannot proceed, the controller holds the program counter and the fetch/decode register. In the same cycle it forces the control fields entering execute to zero, which inserts a no-op. Fetch always continues at the next sequential address, so branches are predicted not taken. When a branch in decode turns out to be taken and no stall is pending, the controller flushes the single wrongly fetched instruction in the fetch/decode register. The block is purely combinational detection and control. Register storage, the branch comparator and the forwarding muxes are outside it.

Top module: `hz_stall_ctrl`

## Requirements
- R1: Whenever a stall is raised, `pc_write_en` and `ifid_write_en` are 0 and `idex_bubble` is 1 in that same cycle. Otherwise the two enables are 1 and `idex_bubble` is 0.
- R2: A load-use stall is raised when execute holds a load (`ex_mem_read`=1 and `ex_reg_write`=1) whose destination equals `id_rs1`, or equals `id_rs2` while `id_rs2_used`=1.
- R3: When decode holds a store (`id_is_store`=1), a load in execute that matches only `id_rs2`, the store data, raises no stall. A match on `id_rs1`, the store address, still stalls.
- R4: A branch in decode (`id_is_branch`=1) stalls when execute holds any register-writing instruction whose destination equals `id_rs1` or `id_rs2`.
- R5: A branch in decode stalls when the memory stage holds a load (`mem_mem_read`=1 and `mem_reg_write`=1) whose destination equals `id_rs1` or `id_rs2`. A load directly ahead of a branch therefore costs two stall cycles. A register-writing non-load in the memory stage never stalls.
- R6: A destination index of 0 never causes a stall.
- R7: A producer with its register-write flag at 0 never causes a stall, whatever its memory-read flag is.
- R8: `ifid_flush` is 1 exactly when `id_is_branch`=1, `id_br_taken`=1 and no stall is raised.
- R9: While stalled, `id_br_taken` is ignored and `ifid_flush` stays 0.
- R10: With no branch in decode and no matching producer, the pipeline advances: both enables are 1, and `idex_bubble` and `ifid_flush` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_IDX_W | First source index of the decode instruction |
| id_rs2 | input | REG_IDX_W | Second source index of the decode instruction |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (second source is store data) |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Branch comparator result for the decode branch |
| ex_rd | input | REG_IDX_W | Destination index of the execute instruction |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_IDX_W | Destination index of the memory-stage instruction |
| mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| mem_mem_read | input | 1 | Memory-stage instruction is a load |
| pc_write_en | output | 1 | Program counter may update |
| ifid_write_en | output | 1 | Fetch/decode register may update |
| idex_bubble | output | 1 | Zero the control fields entering execute |
| ifid_flush | output | 1 | Clear the fetch/decode register |

## Verification
The bench sweeps every input combination with two-bit register indices, so each aliasing of sources and destinations is covered. This includes index 0 and producers with odd flag mixes. A design that missed the store-data exception would stall needlessly on load-then-store. One that ignored the memory-stage load would let a branch compare a stale value. One that forgot the x0 or write-flag guards would stall on instructions that produce nothing. A directed load-then-branch sequence checks the two-cycle stall and confirms the flush comes only in the cycle after the stall clears. A design that let flush win over stall would discard the branch that is still waiting in decode.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Per-producer comparison result against the two decode sources.
  typedef struct packed {
    logic rs2;
    logic rs1;
  } src_hit_t;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hz_match.sv
module hz_match
  import hz_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] prod_rd,
  input  logic                 prod_wr,
  input  logic [REG_IDX_W-1:0] src_a,
  input  logic [REG_IDX_W-1:0] src_b,
  output src_hit_t             hit
);
  localparam logic [REG_IDX_W-1:0] ZERO_IDX = '0;

  logic [REG_IDX_W-1:0] srcs [NUM_SRC];
  logic [NUM_SRC-1:0]   eq;
  logic                 live;

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;

  // A producer only matters if it writes a real register.
  assign live = prod_wr && (prod_rd != ZERO_IDX);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign eq[i] = live && (prod_rd == srcs[i]);
  end

  assign hit.rs1 = eq[0];
  assign hit.rs2 = eq[1];
endmodule

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
(
  input  src_hit_t ex_hit,
  input  src_hit_t mem_hit,
  input  logic     ex_is_load,
  input  logic     mem_is_load,
  input  logic     rs2_used,
  input  logic     is_store,
  input  logic     is_branch,
  output logic     stall
);
  logic rs2_needs_now;
  logic load_use;
  logic br_wait_ex;
  logic br_wait_mem;

  always_comb begin
    // Store data can be taken from the load result later; only addresses wait.
    rs2_needs_now = rs2_used && !is_store;
    load_use      = ex_is_load && (ex_hit.rs1 || (ex_hit.rs2 && rs2_needs_now));
    br_wait_ex    = is_branch && (ex_hit.rs1 || ex_hit.rs2);
    br_wait_mem   = is_branch && mem_is_load && (mem_hit.rs1 || mem_hit.rs2);
    stall         = load_use || br_wait_ex || br_wait_mem;
  end
endmodule

// File: rtl/hz_flow.sv
module hz_flow (
  input  logic stall,
  input  logic is_branch,
  input  logic br_taken,
  output logic pc_write_en,
  output logic ifid_write_en,
  output logic idex_bubble,
  output logic ifid_flush
);
  always_comb begin
    pc_write_en   = !stall;
    ifid_write_en = !stall;
    idex_bubble   = stall;
    // A stalled branch has no valid outcome yet.
    ifid_flush    = is_branch && br_taken && !stall;
  end
endmodule

// File: rtl/hz_stall_ctrl.sv
module hz_stall_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_IDX_W = 5
) (
  input  logic [REG_IDX_W-1:0] id_rs1,
  input  logic [REG_IDX_W-1:0] id_rs2,
  input  logic                 id_rs2_used,
  input  logic                 id_is_store,
  input  logic                 id_is_branch,
  input  logic                 id_br_taken,
  input  logic [REG_IDX_W-1:0] ex_rd,
  input  logic                 ex_reg_write,
  input  logic                 ex_mem_read,
  input  logic [REG_IDX_W-1:0] mem_rd,
  input  logic                 mem_reg_write,
  input  logic                 mem_mem_read,
  output logic                 pc_write_en,
  output logic                 ifid_write_en,
  output logic                 idex_bubble,
  output logic                 ifid_flush
);
  src_hit_t ex_hit;
  src_hit_t mem_hit;
  logic     stall;

  hz_match #(.REG_IDX_W(REG_IDX_W)) u_ex_match (
    .prod_rd (ex_rd),
    .prod_wr (ex_reg_write),
    .src_a   (id_rs1),
    .src_b   (id_rs2),
    .hit     (ex_hit)
  );

  hz_match #(.REG_IDX_W(REG_IDX_W)) u_mem_match (
    .prod_rd (mem_rd),
    .prod_wr (mem_reg_write),
    .src_a   (id_rs1),
    .src_b   (id_rs2),
    .hit     (mem_hit)
  );

  hz_detect u_detect (
    .ex_hit      (ex_hit),
    .mem_hit     (mem_hit),
    .ex_is_load  (ex_mem_read),
    .mem_is_load (mem_mem_read),
    .rs2_used    (id_rs2_used),
    .is_store    (id_is_store),
    .is_branch   (id_is_branch),
    .stall       (stall)
  );

  hz_flow u_flow (
    .stall         (stall),
    .is_branch     (id_is_branch),
    .br_taken      (id_br_taken),
    .pc_write_en   (pc_write_en),
    .ifid_write_en (ifid_write_en),
    .idex_bubble   (idex_bubble),
    .ifid_flush    (ifid_flush)
  );
endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
  parameter int unsigned REG_IDX_W = 5
) (
  input logic [REG_IDX_W-1:0] id_rs1,
  input logic [REG_IDX_W-1:0] id_rs2,
  input logic                 id_is_branch,
  input logic                 id_br_taken,
  input logic [REG_IDX_W-1:0] ex_rd,
  input logic                 ex_reg_write,
  input logic                 ex_mem_read,
  input logic [REG_IDX_W-1:0] mem_rd,
  input logic                 mem_reg_write,
  input logic                 pc_write_en,
  input logic                 ifid_write_en,
  input logic                 idex_bubble,
  input logic                 ifid_flush
);
  logic ex_quiet;
  logic mem_quiet;

  assign ex_quiet  = !ex_reg_write || (ex_rd == '0);
  assign mem_quiet = !mem_reg_write || (mem_rd == '0);

  always_comb begin
    // R1
    stall_holds_all_chk: assert (pc_write_en == ifid_write_en && idex_bubble == !pc_write_en);
    // R2
    load_use_stall_chk: assert (!(ex_reg_write && ex_mem_read && ex_rd != '0 && ex_rd == id_rs1) || idex_bubble);
    // R4
    branch_ex_stall_chk: assert (!(id_is_branch && ex_reg_write && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2)) || idex_bubble);
    // R6
    quiet_no_stall_chk: assert (!(ex_quiet && mem_quiet) || !idex_bubble);
    // R8
    flush_when_taken_chk: assert (ifid_flush == (id_is_branch && id_br_taken && pc_write_en));
    // R9
    stall_blocks_flush_chk: assert (!(idex_bubble && ifid_flush));
  end
endmodule

bind hz_stall_ctrl hz_stall_chk #(.REG_IDX_W(REG_IDX_W)) u_chk (
  .id_rs1        (id_rs1),
  .id_rs2        (id_rs2),
  .id_is_branch  (id_is_branch),
  .id_br_taken   (id_br_taken),
  .ex_rd         (ex_rd),
  .ex_reg_write  (ex_reg_write),
  .ex_mem_read   (ex_mem_read),
  .mem_rd        (mem_rd),
  .mem_reg_write (mem_reg_write),
  .pc_write_en   (pc_write_en),
  .ifid_write_en (ifid_write_en),
  .idex_bubble   (idex_bubble),
  .ifid_flush    (ifid_flush)
);

// File: tb/hz_stall_ctrl_test.sv
module hz_stall_ctrl_test;
  localparam int unsigned W = 2;
  localparam time CLK_PERIOD = 10ns;

  logic clk;
  logic rst_n;
  logic [W-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic id_rs2_used, id_is_store, id_is_branch, id_br_taken;
  logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read;
  logic pc_write_en, ifid_write_en, idex_bubble, ifid_flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hz_stall_ctrl #(.REG_IDX_W(W)) uut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
    .id_is_store(id_is_store), .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
    .ex_rd(ex_rd), .ex_reg_write(ex_reg_write), .ex_mem_read(ex_mem_read),
    .mem_rd(mem_rd), .mem_reg_write(mem_reg_write), .mem_mem_read(mem_mem_read),
    .pc_write_en(pc_write_en), .ifid_write_en(ifid_write_en),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input logic [15:0] v);
    @(posedge clk);
    id_rs1        = v[1:0];
    id_rs2        = v[3:2];
    id_rs2_used   = v[4];
    id_is_store   = v[5];
    id_is_branch  = v[6];
    id_br_taken   = v[7];
    ex_rd         = v[9:8];
    ex_reg_write  = v[10];
    ex_mem_read   = v[11];
    mem_rd        = v[13:12];
    mem_reg_write = v[14];
    mem_mem_read  = v[15];
    @(negedge clk);
  endtask

  // Outputs packed {pc_we, ifid_we, bubble, flush}
  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {pc_write_en, ifid_write_en, idex_bubble, ifid_flush};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b (rs1=%0d rs2=%0d ex_rd=%0d mem_rd=%0d)",
               tag, act, exp, id_rs1, id_rs2, ex_rd, mem_rd);
    end
  endtask

  function automatic logic [3:0] pack(input logic stall, input logic flush);
    return {!stall, !stall, stall, flush};
  endfunction

  // Encode helper: fields in the order the drive task unpacks them.
  function automatic logic [15:0] enc(
    input int rs1, input int rs2, input bit r2u, input bit st, input bit br, input bit tk,
    input int erd, input bit ewr, input bit emr, input int mrd, input bit mwr, input bit mmr);
    logic [15:0] v;
    v = {mmr, mwr, mrd[1:0], emr, ewr, erd[1:0], tk, br, st, r2u, rs2[1:0], rs1[1:0]};
    return v;
  endfunction

  initial begin
    rst_n = 1'b0;
    drive(16'h0000);
    // R10 idle state: nothing in flight
    check("R10", 4'b1100);
    rst_n = 1'b1;

    // R2 load in execute feeds rs1 of an ALU op
    drive(enc(1, 2, 1, 0, 0, 0, 1, 1, 1, 0, 0, 0)); check("R2", pack(1, 0));
    // R2 match on rs2 while rs2 is read
    drive(enc(3, 2, 1, 0, 0, 0, 2, 1, 1, 0, 0, 0)); check("R2", pack(1, 0));
    // R2 match on rs2 that the instruction does not read
    drive(enc(3, 2, 0, 0, 0, 0, 2, 1, 1, 0, 0, 0)); check("R2", pack(0, 0));
    // R3 load then store using it only as data
    drive(enc(3, 2, 1, 1, 0, 0, 2, 1, 1, 0, 0, 0)); check("R3", pack(0, 0));
    // R3 load then store using it as address
    drive(enc(2, 3, 1, 1, 0, 0, 2, 1, 1, 0, 0, 0)); check("R3", pack(1, 0));
    // R4 ALU producer in execute feeds a taken branch
    drive(enc(1, 3, 1, 0, 1, 1, 3, 1, 0, 0, 0, 0)); check("R4", pack(1, 0));
    // R5 non-load in memory stage does not stall a branch
    drive(enc(1, 3, 1, 0, 1, 0, 0, 0, 0, 1, 1, 0)); check("R5", pack(0, 0));
    // R6 destination x0 everywhere
    drive(enc(0, 0, 1, 0, 1, 0, 0, 1, 1, 0, 1, 1)); check("R6", pack(0, 0));
    // R7 non-writer with memory-read flag set
    drive(enc(1, 1, 1, 0, 1, 0, 1, 0, 1, 1, 0, 1)); check("R7", pack(0, 0));
    // R8 taken branch, no hazard
    drive(enc(1, 2, 1, 0, 1, 1, 3, 1, 0, 3, 1, 1)); check("R8", pack(0, 1));
    // R9 taken branch while stalled by a load in memory
    drive(enc(1, 2, 1, 0, 1, 1, 0, 0, 0, 2, 1, 1)); check("R9", pack(1, 0));

    // R5 load directly ahead of a taken branch: two stall cycles, then flush
    drive(enc(2, 1, 1, 0, 1, 1, 2, 1, 1, 0, 0, 0)); check("R5", pack(1, 0));
    drive(enc(2, 1, 1, 0, 1, 1, 0, 0, 0, 2, 1, 1)); check("R5", pack(1, 0));
    drive(enc(2, 1, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0)); check("R8", pack(0, 1));

    // R1 exhaustive sweep, expected values from the requirement text
    for (int n = 0; n < 65536; n++) begin
      logic [15:0] v;
      logic ex_live, mem_live, ex_m1, ex_m2, mem_m1, mem_m2;
      logic lu, bex, bmem, stall, flush;
      string tag;
      v = n[15:0];
      drive(v);
      ex_live  = v[10] && (v[9:8] != 2'd0);
      mem_live = v[14] && (v[13:12] != 2'd0);
      ex_m1    = ex_live && (v[9:8] == v[1:0]);
      ex_m2    = ex_live && (v[9:8] == v[3:2]);
      mem_m1   = mem_live && (v[13:12] == v[1:0]);
      mem_m2   = mem_live && (v[13:12] == v[3:2]);
      lu       = v[11] && (ex_m1 || (ex_m2 && v[4] && !v[5]));
      bex      = v[6] && (ex_m1 || ex_m2);
      bmem     = v[6] && v[15] && (mem_m1 || mem_m2);
      stall    = lu || bex || bmem;
      flush    = v[6] && v[7] && !stall;
      if (lu) tag = "R2";
      else if (bex) tag = "R4";
      else if (bmem) tag = "R5";
      else if (flush) tag = "R8";
      else tag = "R10";
      check(tag, pack(stall, flush));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule